// File: doc/BRIEF.md
# Status Register Field-Masked Writer

This block holds the processor's 32-bit current status word and one saved status word for each exception bank that has one. It applies move-to-status writes. Each write carries a 4-bit field mask, and that mask, together with the privilege of the current bank, decides which fields of the target word take the new data. The mask is taken from instruction bits 19..16, so mask bit 3 corresponds to instruction bit 19 and mask bit 0 to instruction bit 16. Instruction decode happens outside the block.

The current word drives several outputs:
- the N, Z, C and V flags, at bits 31..28;
- the IRQ and FIQ disable bits, at bits 7 and 6;
- the 5-bit mode field, at bits 4..0;
- a bank index decoded from the mode field.

A one-cycle strobe tells the register file that a write changed the mode field and that it must switch banks. A strap input selects between the full 32-bit status layout and a reduced legacy layout.

Reads of the saved word always refer to the current bank. In a bank that has no saved word, the saved-word output returns the current word instead.

Top module: `psr_writer`

## Requirements
- R1: A synchronous active-high reset loads the current word with 0x000000D3 (supervisor mode, IRQ and FIQ disabled). When the strap is low, that value is reduced by the legacy mask of R9. All saved words clear to zero, and the mode-change strobe is low.
- R2: In user mode the current word takes only bits 31..28 from the data, and only when mask bit 3 is set. Every other bit is kept.
- R3: In any other mode, a mask of exactly 4'b1001 replaces the whole current word with the data.
- R4: In any other mode, for any mask other than 4'b1001, mask bit 0 writes bits 7..6 and 4..0 and nothing else. When bit 0 is set, it wins over bit 3: the flags are not written.
- R5: In any other mode, mask bit 3 alone, with bit 0 clear, writes only bits 31..28. A mask with bits 0 and 3 both clear leaves the word unchanged.
- R6: A write with wr_saved high goes to the saved word of the current bank, using the privileged field rules of R3 to R5. It leaves the current word unchanged.
- R7: A saved-word write is ignored in the user bank (mode 0x10) and the system bank (mode 0x1F). The saved words of the other banks keep their values.
- R8: saved_view shows the current bank's saved word. In the user and system banks it shows the current word.
- R9: While mode32 is low, every write to the current word keeps only bits 31..28, 7..6 and 1..0 of the result. All other bits are zero.
- R10: Bank codes follow the mode field:

  | Mode | Bank | bank_id |
  |---|---|---|
  | 0x10 or 0x00 | user | 0 |
  | 0x11 or 0x01 | FIQ | 1 |
  | 0x12 or 0x02 | IRQ | 2 |
  | 0x13 or 0x03 | supervisor | 3 |
  | 0x17 | abort | 4 |
  | 0x1B | undefined | 5 |
  | 0x1F | system | 6 |
  | any other value | invalid | 7 |

  mode_chg is high for exactly the one cycle after a write that changed the mode field.
- R11: flag_n, flag_z, flag_c and flag_v show bits 31..28 of the current word, irq_dis shows bit 7, fiq_dis shows bit 6 and mode_field shows bits 4..0. All of them update in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_saved | input | 1 | 1 selects the saved word of the current bank, 0 selects the current word |
| fld_mask | input | 4 | Field mask from instruction bits 19..16 |
| wr_data | input | 32 | Write data |
| mode32 | input | 1 | Strap: 1 selects the full 32-bit layout, 0 selects the legacy reduced layout |
| cur_psr | output | 32 | Current status word |
| saved_view | output | 32 | Saved word of the current bank, or the current word in a bank without one |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| irq_dis | output | 1 | IRQ disable |
| fiq_dis | output | 1 | FIQ disable |
| mode_field | output | 5 | Current mode |
| bank_id | output | 3 | Bank decoded from the mode |
| mode_chg | output | 1 | One-cycle mode-change strobe |

## Verification
The writer is driven with several masks, and each one separates a different branch of the field selection:
- 4'b1001 checks the full-word write.
- 4'b1011 shows that the control field wins over the flags.
- 4'b1000 writes the flags alone.
- 4'b0110 must change nothing.

The same masks are applied again in user mode, where only the flag path may act. Saved-word writes are made in the IRQ, supervisor and system banks. The bench then moves between those banks and checks that each saved word kept its own value and that the system-bank write was dropped. A final pass with the strap low, using all-ones data, shows that the legacy layout clears every field outside the reduced set.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int PSR_W   = 32;
  localparam int MODE_W  = 5;
  localparam int BANK_W  = 3;

  localparam logic [PSR_W-1:0] FLAG_MASK  = 32'hF000_0000;
  localparam logic [PSR_W-1:0] CTRL_MASK  = 32'h0000_00DF;
  localparam logic [PSR_W-1:0] KEEP26     = 32'hF000_00C3;
  localparam logic [PSR_W-1:0] RESET_VAL  = 32'h0000_00D3;
  localparam logic [3:0]       FULL_MASK  = 4'b1001;

  localparam int FLAG_N_POS = 31;
  localparam int FLAG_Z_POS = 30;
  localparam int FLAG_C_POS = 29;
  localparam int FLAG_V_POS = 28;
  localparam int IRQ_POS    = 7;
  localparam int FIQ_POS    = 6;

  typedef enum logic [BANK_W-1:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5,
    BK_SYS = 3'd6,
    BK_BAD = 3'd7
  } bank_e;
endpackage

// File: rtl/psr_bank_decode.sv
module psr_bank_decode
  import psr_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output bank_e             bank,
  output logic              has_saved,
  output logic              is_user
);
  always_comb begin
    case (mode)
      5'h00, 5'h10: bank = BK_USR;
      5'h01, 5'h11: bank = BK_FIQ;
      5'h02, 5'h12: bank = BK_IRQ;
      5'h03, 5'h13: bank = BK_SVC;
      5'h17:        bank = BK_ABT;
      5'h1B:        bank = BK_UND;
      5'h1F:        bank = BK_SYS;
      default:      bank = BK_BAD;
    endcase
  end

  always_comb begin
    has_saved = (bank == BK_FIQ) || (bank == BK_IRQ) || (bank == BK_SVC) ||
                (bank == BK_ABT) || (bank == BK_UND);
    is_user   = (bank == BK_USR);
  end
endmodule

// File: rtl/psr_field_merge.sv
module psr_field_merge
  import psr_pkg::*;
(
  input  logic [PSR_W-1:0] old_val,
  input  logic [PSR_W-1:0] new_val,
  input  logic [3:0]       mask,
  input  logic             privileged,
  output logic [PSR_W-1:0] merged
);
  logic [PSR_W-1:0] sel;

  always_comb begin
    sel = '0;
    if (privileged) begin
      if (mask == FULL_MASK)  sel = '1;
      else if (mask[0])       sel = CTRL_MASK;
      else if (mask[3])       sel = FLAG_MASK;
    end else if (mask[3]) begin
      sel = FLAG_MASK;
    end
    merged = (new_val & sel) | (old_val & ~sel);
  end
endmodule

// File: rtl/psr_saved_store.sv
module psr_saved_store
  import psr_pkg::*;
#(
  parameter int WIDTH  = PSR_W,
  parameter int ADDR_W = BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst)
        mem[g] <= '0;
      else if (we && (addr == ADDR_W'(g)))
        mem[g] <= wdata;
    end
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/psr_writer.sv
module psr_writer
  import psr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        wr_saved,
  input  logic [3:0]  fld_mask,
  input  logic [31:0] wr_data,
  input  logic        mode32,
  output logic [31:0] cur_psr,
  output logic [31:0] saved_view,
  output logic        flag_n,
  output logic        flag_z,
  output logic        flag_c,
  output logic        flag_v,
  output logic        irq_dis,
  output logic        fiq_dis,
  output logic [4:0]  mode_field,
  output logic [2:0]  bank_id,
  output logic        mode_chg
);
  logic [PSR_W-1:0] cur_q;
  logic             chg_q;
  bank_e            bank;
  logic             has_saved;
  logic             is_user;
  logic [PSR_W-1:0] cur_merged;
  logic [PSR_W-1:0] cur_next;
  logic [PSR_W-1:0] sav_rd;
  logic [PSR_W-1:0] sav_merged;
  logic             cur_we;
  logic             sav_we;

  psr_bank_decode u_dec (
    .mode      (cur_q[MODE_W-1:0]),
    .bank      (bank),
    .has_saved (has_saved),
    .is_user   (is_user)
  );

  psr_field_merge u_cur_merge (
    .old_val    (cur_q),
    .new_val    (wr_data),
    .mask       (fld_mask),
    .privileged (!is_user),
    .merged     (cur_merged)
  );

  psr_field_merge u_sav_merge (
    .old_val    (sav_rd),
    .new_val    (wr_data),
    .mask       (fld_mask),
    .privileged (1'b1),
    .merged     (sav_merged)
  );

  psr_saved_store #(.WIDTH(PSR_W), .ADDR_W(BANK_W)) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (sav_we),
    .addr  (bank),
    .wdata (sav_merged),
    .rdata (sav_rd)
  );

  assign cur_we   = wr_en && !wr_saved;
  assign sav_we   = wr_en && wr_saved && has_saved;
  assign cur_next = mode32 ? cur_merged : (cur_merged & KEEP26);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= mode32 ? RESET_VAL : (RESET_VAL & KEEP26);
      chg_q <= 1'b0;
    end else begin
      chg_q <= cur_we && (cur_next[MODE_W-1:0] != cur_q[MODE_W-1:0]);
      if (cur_we)
        cur_q <= cur_next;
    end
  end

  assign cur_psr    = cur_q;
  assign saved_view = has_saved ? sav_rd : cur_q;
  assign flag_n     = cur_q[FLAG_N_POS];
  assign flag_z     = cur_q[FLAG_Z_POS];
  assign flag_c     = cur_q[FLAG_C_POS];
  assign flag_v     = cur_q[FLAG_V_POS];
  assign irq_dis    = cur_q[IRQ_POS];
  assign fiq_dis    = cur_q[FIQ_POS];
  assign mode_field = cur_q[MODE_W-1:0];
  assign bank_id    = bank;
  assign mode_chg   = chg_q;
endmodule

// File: rtl/psr_writer_chk.sv
module psr_writer_chk
  import psr_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic        wr_saved,
  input logic [3:0]  fld_mask,
  input logic [31:0] wr_data,
  input logic        mode32,
  input logic [31:0] cur_psr,
  input logic [31:0] saved_view,
  input logic [2:0]  bank_id,
  input logic        mode_chg
);
  assert_user_flags_only_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_saved && bank_id == BK_USR && mode32)
      |=> cur_psr[27:0] == $past(cur_psr[27:0]));

  assert_full_write_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_saved && bank_id != BK_USR && fld_mask == FULL_MASK && mode32)
      |=> cur_psr == $past(wr_data));

  assert_empty_mask_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_saved && !fld_mask[0] && !fld_mask[3] && mode32)
      |=> cur_psr == $past(cur_psr));

  assert_saved_target_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_saved) |=> cur_psr == $past(cur_psr));

  assert_no_saved_view_R8: assert property (@(posedge clk) disable iff (rst)
    (bank_id == BK_USR || bank_id == BK_SYS) |-> saved_view == cur_psr);

  assert_legacy_mask_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_saved && !mode32) |=> (cur_psr & ~KEEP26) == 32'h0);

  assert_strobe_real_R10: assert property (@(posedge clk) disable iff (rst)
    mode_chg |-> cur_psr[4:0] != $past(cur_psr[4:0]));
endmodule

bind psr_writer psr_writer_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .wr_saved   (wr_saved),
  .fld_mask   (fld_mask),
  .wr_data    (wr_data),
  .mode32     (mode32),
  .cur_psr    (cur_psr),
  .saved_view (saved_view),
  .bank_id    (bank_id),
  .mode_chg   (mode_chg)
);

// File: tb/sim_psr_writer.sv
module sim_psr_writer;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_saved = 1'b0;
  logic [3:0]  fld_mask = 4'h0;
  logic [31:0] wr_data = 32'h0;
  logic        mode32 = 1'b1;
  logic [31:0] cur_psr;
  logic [31:0] saved_view;
  logic        flag_n, flag_z, flag_c, flag_v, irq_dis, fiq_dis;
  logic [4:0]  mode_field;
  logic [2:0]  bank_id;
  logic        mode_chg;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  psr_writer u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_saved(wr_saved),
    .fld_mask(fld_mask), .wr_data(wr_data), .mode32(mode32),
    .cur_psr(cur_psr), .saved_view(saved_view),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
    .irq_dis(irq_dis), .fiq_dis(fiq_dis), .mode_field(mode_field),
    .bank_id(bank_id), .mode_chg(mode_chg)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    mode32 = strap;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic do_write(input logic sav, input logic [3:0] m, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_saved = sav; fld_mask = m; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_saved = 1'b0;
  endtask

  task automatic t_reset32;
    do_reset(1'b1);
    chk("R1", "cur", cur_psr, 32'h0000_00D3);
    chk("R1", "strobe", {31'b0, mode_chg}, 32'h0);
    chk("R1", "saved svc", saved_view, 32'h0);
    chk("R11", "irq/fiq", {30'b0, irq_dis, fiq_dis}, 32'h3);
    chk("R10", "bank svc", {29'b0, bank_id}, 32'd3);
  endtask

  task automatic t_full_write;
    do_write(1'b0, 4'b1001, 32'hA000_00D2);
    chk("R3", "cur", cur_psr, 32'hA000_00D2);
    chk("R10", "strobe", {31'b0, mode_chg}, 32'h1);
    chk("R10", "bank irq", {29'b0, bank_id}, 32'd2);
    chk("R11", "nzcv", {28'b0, flag_n, flag_z, flag_c, flag_v}, 32'hA);
    chk("R11", "mode", {27'b0, mode_field}, 32'h12);
  endtask

  task automatic t_saved_irq;
    do_write(1'b1, 4'b1001, 32'h1234_5678);
    chk("R6", "saved irq", saved_view, 32'h1234_5678);
    chk("R6", "cur kept", cur_psr, 32'hA000_00D2);
  endtask

  task automatic t_priority;
    do_write(1'b0, 4'b1011, 32'hF000_0013);
    chk("R4", "ctrl wins", cur_psr, 32'hA000_0013);
    chk("R10", "strobe", {31'b0, mode_chg}, 32'h1);
    chk("R8", "saved svc distinct", saved_view, 32'h0);
  endtask

  task automatic t_flags_only;
    do_write(1'b0, 4'b1000, 32'h5FFF_FFFF);
    chk("R5", "flags only", cur_psr, 32'h5000_0013);
    chk("R10", "no strobe", {31'b0, mode_chg}, 32'h0);
    do_write(1'b0, 4'b0110, 32'hFFFF_FFFF);
    chk("R5", "empty mask", cur_psr, 32'h5000_0013);
  endtask

  task automatic t_saved_partial;
    do_write(1'b1, 4'b0001, 32'hFFFF_FFD1);
    chk("R6", "saved ctrl field", saved_view, 32'h0000_00D1);
  endtask

  task automatic t_system_bank;
    do_write(1'b0, 4'b1001, 32'h0000_001F);
    chk("R10", "bank sys", {29'b0, bank_id}, 32'd6);
    chk("R8", "view=cur sys", saved_view, 32'h0000_001F);
    do_write(1'b1, 4'b1001, 32'hCAFE_F00D);
    chk("R7", "sys ignored", saved_view, 32'h0000_001F);
    do_write(1'b0, 4'b1001, 32'h0000_00D3);
    chk("R7", "svc kept", saved_view, 32'h0000_00D1);
    do_write(1'b0, 4'b1001, 32'h0000_00D2);
    chk("R7", "irq kept", saved_view, 32'h1234_5678);
  endtask

  task automatic t_user;
    do_write(1'b0, 4'b1001, 32'h0000_0010);
    chk("R10", "bank usr", {29'b0, bank_id}, 32'd0);
    chk("R8", "view=cur usr", saved_view, 32'h0000_0010);
    do_write(1'b0, 4'b1001, 32'hF000_00D3);
    chk("R2", "flags only", cur_psr, 32'hF000_0010);
    chk("R2", "no strobe", {31'b0, mode_chg}, 32'h0);
    do_write(1'b0, 4'b0111, 32'hFFFF_FFFF);
    chk("R2", "no bit3", cur_psr, 32'hF000_0010);
    do_write(1'b1, 4'b1001, 32'hDEAD_BEEF);
    chk("R7", "usr saved ignored", saved_view, 32'hF000_0010);
  endtask

  task automatic t_strap;
    do_reset(1'b0);
    chk("R1", "reset legacy", cur_psr, 32'h0000_00C3);
    chk("R10", "bank svc26", {29'b0, bank_id}, 32'd3);
    do_write(1'b0, 4'b1001, 32'hFFFF_FFFF);
    chk("R9", "legacy mask", cur_psr, 32'hF000_00C3);
    chk("R10", "no strobe", {31'b0, mode_chg}, 32'h0);
    do_write(1'b0, 4'b1001, 32'h0000_0011);
    chk("R9", "mode low bits", cur_psr, 32'h0000_0001);
    chk("R10", "bank fiq", {29'b0, bank_id}, 32'd1);
    chk("R10", "strobe", {31'b0, mode_chg}, 32'h1);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset32();
    t_full_write();
    t_saved_irq();
    t_priority();
    t_flags_only();
    t_saved_partial();
    t_system_bank();
    t_user();
    t_strap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule